// File: doc/BRIEF.md
# Branch Target Address Generator

This block forms the destination address of a control transfer for a byte-oriented microcontroller core with a 16-bit program counter. It is purely combinational. The decoder supplies four things: the address of the first byte of the instruction that follows the branch, a 2-bit code for the kind of target, the branch opcode, and up to two operand bytes. The block returns the 16-bit address that the fetch unit loads when the transfer happens.

Three target forms are supported. The long form carries a complete 16-bit address, so it can reach any location in the 64 KB code space. The page form carries an 11-bit address and stays inside the 2 KB page that holds the following instruction. The relative form carries a signed byte, which is added to the following instruction's address.

The block does not decide whether a conditional branch is taken. It does not fetch code and it does not save return addresses. The decoder places the relevant operand byte on `opnd_a_i` for each kind.

Top module: `branch_target_gen`

## Requirements
- R1: With `kind_i` = 2'b00 (long form), `target_o` equals `{opnd_a_i, opnd_b_i}`, with `opnd_a_i` as the high byte.
- R2: With `kind_i` = 2'b01 (page form), `target_o[15:11]` equals `next_pc_i[15:11]`.
- R3: With `kind_i` = 2'b01, `target_o[10:8]` equals `opcode_i[7:5]` and `target_o[7:0]` equals `opnd_a_i`.
- R4: With `kind_i` = 2'b10 (relative form), `target_o` equals `next_pc_i` plus `opnd_a_i` read as a two's-complement byte, taken modulo 2^16.
- R5: In the relative form, the target never lies more than 127 bytes after or 128 bytes before `next_pc_i`. Offset 8'h7F gives +127 and offset 8'h80 gives -128.
- R6: A relative sum wraps around the 64 KB space. For example, 16'hFFF0 + 8'h20 gives 16'h0010, and 16'h0005 + 8'hF0 gives 16'hFFF5.
- R7: With `kind_i` = 2'b11 (unused code), `target_o` equals `next_pc_i` unchanged.
- R8: The page in the page form comes from the following instruction's address. With `next_pc_i` = 16'h0800, the target lies in the range 16'h0800 to 16'h0FFF even when the branch itself ended the previous page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| next_pc_i | input | 16 | Address of the first byte of the following instruction |
| kind_i | input | 2 | Target form: 00 long, 01 page, 10 relative, 11 unused |
| opcode_i | input | 8 | Branch opcode; bits 7:5 are the high bits of the page-form address |
| opnd_a_i | input | 8 | First operand byte: long high byte, page low byte, or relative offset |
| opnd_b_i | input | 8 | Second operand byte: long low byte |
| target_o | output | 16 | Computed branch target |

## Verification
The checker tests the following on every cycle:
- the long-form copy;
- the preserved page bits and the placement of the 11-bit field;
- the modular relative difference;
- the bound on the relative distance;
- the pass-through for the unused code.

Only the bench scenarios can show that specific corner values land correctly:
- the exact offsets at the ends of the range;
- wrap-around at both ends of the address space;
- a branch that ends one page and has its target taken from the next page.

// File: rtl/branch_target_pkg.sv
package branch_target_pkg;
  typedef enum logic [1:0] {
    BR_LONG = 2'b00,
    BR_PAGE = 2'b01,
    BR_REL  = 2'b10,
    BR_NONE = 2'b11
  } br_kind_e;
endpackage

// File: rtl/btg_long.sv
module btg_long #(
  parameter int BYTE_W = 8,
  localparam int PC_W = 2 * BYTE_W
) (
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  output logic [PC_W-1:0]   tgt_o
);
  assign tgt_o = {hi_i, lo_i};
endmodule

// File: rtl/btg_page.sv
module btg_page #(
  parameter int BYTE_W    = 8,
  parameter int PAGE_HI_W = 3,
  localparam int PC_W   = 2 * BYTE_W,
  localparam int PAGE_W = PAGE_HI_W + BYTE_W
) (
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic [BYTE_W-1:0] opnd_i,
  output logic [PC_W-1:0]   tgt_o
);
  logic [PAGE_W-1:0] field;

  // high field bits ride in the top of the opcode
  assign field = {opcode_i[BYTE_W-1 -: PAGE_HI_W], opnd_i};
  assign tgt_o = {next_pc_i[PC_W-1:PAGE_W], field};
endmodule

// File: rtl/btg_rel.sv
module btg_rel #(
  parameter int BYTE_W = 8,
  localparam int PC_W  = 2 * BYTE_W,
  localparam int EXT_W = PC_W - BYTE_W
) (
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic [BYTE_W-1:0] off_i,
  output logic [PC_W-1:0]   tgt_o
);
  logic [PC_W-1:0] off_ext;

  assign off_ext = {{EXT_W{off_i[BYTE_W-1]}}, off_i};
  assign tgt_o   = next_pc_i + off_ext;  // wraps mod 2^PC_W
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import branch_target_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PAGE_HI_W = 3,
  localparam int PC_W = 2 * BYTE_W
) (
  input  logic [PC_W-1:0]   next_pc_i,
  input  logic [1:0]        kind_i,
  input  logic [BYTE_W-1:0] opcode_i,
  input  logic [BYTE_W-1:0] opnd_a_i,
  input  logic [BYTE_W-1:0] opnd_b_i,
  output logic [PC_W-1:0]   target_o
);
  logic [PC_W-1:0] tgt_long, tgt_page, tgt_rel;
  br_kind_e        kind;

  assign kind = br_kind_e'(kind_i);

  btg_long #(.BYTE_W(BYTE_W)) i_long (
    .hi_i  (opnd_a_i),
    .lo_i  (opnd_b_i),
    .tgt_o (tgt_long)
  );

  btg_page #(.BYTE_W(BYTE_W), .PAGE_HI_W(PAGE_HI_W)) i_page (
    .next_pc_i (next_pc_i),
    .opcode_i  (opcode_i),
    .opnd_i    (opnd_a_i),
    .tgt_o     (tgt_page)
  );

  btg_rel #(.BYTE_W(BYTE_W)) i_rel (
    .next_pc_i (next_pc_i),
    .off_i     (opnd_a_i),
    .tgt_o     (tgt_rel)
  );

  always_comb begin
    unique case (kind)
      BR_LONG: target_o = tgt_long;
      BR_PAGE: target_o = tgt_page;
      BR_REL:  target_o = tgt_rel;
      default: target_o = next_pc_i;
    endcase
  end
endmodule

// File: rtl/branch_target_chk.sv
module branch_target_chk #(
  parameter int BYTE_W    = 8,
  parameter int PAGE_HI_W = 3,
  localparam int PC_W   = 2 * BYTE_W,
  localparam int PAGE_W = PAGE_HI_W + BYTE_W,
  localparam int MAX_FW = (1 << (BYTE_W - 1)) - 1,
  localparam int MAX_BK = (1 << (BYTE_W - 1))
) (
  input logic [PC_W-1:0]   next_pc_i,
  input logic [1:0]        kind_i,
  input logic [BYTE_W-1:0] opcode_i,
  input logic [BYTE_W-1:0] opnd_a_i,
  input logic [BYTE_W-1:0] opnd_b_i,
  input logic [PC_W-1:0]   target_o
);
  logic [PC_W-1:0] diff;
  logic [PC_W-1:0] back;
  logic            fwd;

  assign diff = target_o - next_pc_i;
  assign back = next_pc_i - target_o;
  assign fwd  = (diff < PC_W'(MAX_BK));

  always_comb begin
    if (kind_i == 2'b00) begin
      AST_LONG_EXACT: assert (target_o[PC_W-1:BYTE_W] == opnd_a_i && target_o[BYTE_W-1:0] == opnd_b_i); // R1
    end
    if (kind_i == 2'b01) begin
      AST_PAGE_KEEP: assert (target_o[PC_W-1:PAGE_W] == next_pc_i[PC_W-1:PAGE_W]); // R2
      AST_PAGE_FIELD: assert (target_o[PAGE_W-1:BYTE_W] == opcode_i[BYTE_W-1 -: PAGE_HI_W] && target_o[BYTE_W-1:0] == opnd_a_i); // R3
    end
    if (kind_i == 2'b10) begin
      AST_REL_DIFF: assert (diff[BYTE_W-1:0] == opnd_a_i); // R4
      AST_REL_RANGE: assert (fwd ? (diff <= PC_W'(MAX_FW)) : (back <= PC_W'(MAX_BK))); // R5
    end
    if (kind_i == 2'b11) begin
      AST_UNUSED_HOLD: assert (target_o == next_pc_i); // R7
    end
  end
endmodule

bind branch_target_gen branch_target_chk #(
  .BYTE_W    (BYTE_W),
  .PAGE_HI_W (PAGE_HI_W)
) i_chk (
  .next_pc_i (next_pc_i),
  .kind_i    (kind_i),
  .opcode_i  (opcode_i),
  .opnd_a_i  (opnd_a_i),
  .opnd_b_i  (opnd_b_i),
  .target_o  (target_o)
);

// File: tb/test_branch_target_gen.sv
module test_branch_target_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] next_pc;
  logic [1:0]  kind;
  logic [7:0]  opcode, opnd_a, opnd_b;
  logic [15:0] target;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_gen i_branch_target_gen (
    .next_pc_i (next_pc),
    .kind_i    (kind),
    .opcode_i  (opcode),
    .opnd_a_i  (opnd_a),
    .opnd_b_i  (opnd_b),
    .target_o  (target)
  );

  function automatic int model(int np, int k, int op, int a, int b);
    int off;
    case (k)
      0: return a * 256 + b;
      1: return (np / 2048) * 2048 + ((op / 32) % 8) * 256 + a;
      2: begin
        off = (a >= 128) ? a - 256 : a;
        return (np + off + 65536) % 65536;
      end
      default: return np;
    endcase
  endfunction

  task automatic check(string req, int exp);
    n_chk++;
    if (int'(target) != exp) begin
      n_fail++;
      $display("FAIL %s: np=%h kind=%0d op=%h a=%h b=%h actual=%h expected=%h",
               req, next_pc, kind, opcode, opnd_a, opnd_b, target, exp[15:0]);
    end
  endtask

  task automatic apply(int np, int k, int op, int a, int b, string req);
    @(posedge clk);
    #1;
    next_pc = np[15:0];
    kind    = k[1:0];
    opcode  = op[7:0];
    opnd_a  = a[7:0];
    opnd_b  = b[7:0];
    @(negedge clk);
    check(req, model(np, k, op, a, b));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    next_pc = '0; kind = 2'b00; opcode = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 0);

    // R1 long form
    apply(16'h1234, 0, 8'h12, 8'hAB, 8'hCD, "R1");
    apply(16'h0000, 0, 8'h02, 8'hFF, 8'hFF, "R1");
    // R2 R3 page form
    apply(16'h3456, 1, 8'hE1, 8'h5A, 8'h00, "R2 R3");
    apply(16'hFFFF, 1, 8'h11, 8'h00, 8'h77, "R2 R3");
    apply(16'h07FF, 1, 8'hA1, 8'hC3, 8'h00, "R3");
    // R8 page taken from following instruction
    apply(16'h0800, 1, 8'h01, 8'h10, 8'h00, "R8");
    apply(16'h1000, 1, 8'hF1, 8'hFF, 8'h00, "R8");
    // R4 R5 relative extremes
    apply(16'h4000, 2, 8'h80, 8'h7F, 8'h00, "R5 +127");
    apply(16'h4000, 2, 8'h80, 8'h80, 8'h00, "R5 -128");
    apply(16'h4000, 2, 8'h80, 8'h00, 8'h00, "R4 zero");
    apply(16'h4000, 2, 8'h80, 8'hFF, 8'h00, "R4 -1");
    // R6 wrap
    apply(16'hFFF0, 2, 8'h80, 8'h20, 8'h00, "R6");
    apply(16'h0005, 2, 8'h80, 8'hF0, 8'h00, "R6");
    // R7 unused code
    apply(16'hBEEF, 3, 8'hFF, 8'h12, 8'h34, "R7");
    apply(16'h0000, 3, 8'h00, 8'hFF, 8'hFF, "R7");

    for (int i = 0; i < 400; i++) begin
      int k;
      k = i % 4;
      apply($urandom_range(0, 65535), k, $urandom_range(0, 255),
            $urandom_range(0, 255), $urandom_range(0, 255),
            k == 0 ? "R1 rand" : k == 1 ? "R3 rand" : k == 2 ? "R4 rand" : "R7 rand");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule